// File: doc/BRIEF.md
# Iterative 32-bit Multiplier with High-Half Variants

This block multiplies two 32-bit operands over a fixed number of clock cycles, one multiplier bit per cycle, and returns either the low word of the 64-bit product or one of three flavours of the high word. The high word can treat both operands as unsigned, treat the first as signed and the second as unsigned, or treat both as signed. A separate immediate mode multiplies the first operand by a 16-bit constant that is sign-extended to 32 bits and returns the low word.

A single 32-step loop builds the low word and the unsigned high word side by side. The low word is formed by scanning the multiplier from its top bit with a left-shifting accumulator. The unsigned high word is formed by scanning from the bottom bit, adding into an accumulator that shifts right and keeps the addition's carry as its new top bit. The signed high words are derived from the unsigned one after the loop, by up to two one-cycle correction subtractions that use a saved copy of the original multiplier.

A caller pulses `start` with the operands and mode while `busy` is low, then waits for the one-cycle `done` pulse, at which point `result` holds the answer until the next operation completes.

Top module: `iterMul`

## Requirements
- R1: With `immMode` low and `extCode` = 0x27, `result` is bits [31:0] of opA × opB.
- R2: With `immMode` low and `extCode` = 0x07, `result` is bits [63:32] of the product with both operands taken as unsigned.
- R3: With `immMode` low and `extCode` = 0x17, `result` is bits [63:32] of the product with opA signed and opB unsigned.
- R4: With `immMode` low and `extCode` = 0x1f, or any code other than 0x27, 0x07 and 0x17, `result` is bits [63:32] of the product with both operands signed.
- R5: With `immMode` high, `result` is bits [31:0] of opA × the sign-extended `imm16`; `extCode` and `opB` have no effect.
- R6: Counting the clock edge that accepts `start` as edge 0, `done` is visible after edge 33 for the low-word and unsigned-high modes, after edge 34 for the signed-A high mode, and after edge 35 for the signed-signed high mode.
- R7: `done` is a single-cycle pulse; `busy` rises on the edge that accepts `start` and is low in the cycle `done` is high.
- R8: A `start` pulse while `busy` is high is ignored: no additional `done` occurs and the running operation's result is unchanged; `result` only changes in a cycle where `done` is high.
- R9: After reset `result` is 0 and `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (ignored while busy) |
| immMode | input | 1 | Use sign-extended imm16 as second operand, low word result |
| extCode | input | 6 | Result selector when immMode is low |
| opA | input | 32 | Multiplicand |
| opB | input | 32 | Multiplier (register mode) |
| imm16 | input | 16 | Immediate multiplier (immediate mode) |
| result | output | 32 | Selected product word, held until the next completion |
| done | output | 1 | One-cycle pulse when result is updated |
| busy | output | 1 | High while an operation is in progress |

## Verification
Results are due 34, 35 or 36 bench cycles after the cycle in which `start` is driven, depending on whether the mode needs zero, one or two corrections. The driver stamps each request with the cycle it was driven and pushes the expected word and expected delay into a queue; the monitor samples on the falling edge, pops on every `done`, and checks both the word and the measured delay, so a result that is right but early or late is still caught. Ignored starts are driven in the middle of a run, and any `done` that arrives with an empty queue is counted as a failure.

// File: rtl/mulPkg.sv
package mulPkg;
  typedef enum logic [1:0] {
    KIND_LOW = 2'd0,
    KIND_UU  = 2'd1,
    KIND_SU  = 2'd2,
    KIND_SS  = 2'd3
  } mulKind_e;

  localparam logic [5:0] CODE_LOW = 6'h27;
  localparam logic [5:0] CODE_UU  = 6'h07;
  localparam logic [5:0] CODE_SU  = 6'h17;

  typedef struct packed {
    logic load;
    logic step;
    logic fixA;
    logic fixB;
    logic publish;
    logic pickLow;
  } mulCtl_t;
endpackage

// File: rtl/mulCtrl.sv
module mulCtrl #(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            immMode,
  input  logic [5:0]      extCode,
  output mulPkg::mulCtl_t ctl,
  output logic            busy,
  output logic            done
);
  import mulPkg::*;

  localparam int CW = $clog2(W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_FIXA, ST_FIXB, ST_PUB
  } state_e;

  state_e   state, stateNext;
  mulKind_e kind, kindIn;
  logic [CW-1:0] stepsLeft;

  always_comb begin
    if (immMode)                kindIn = KIND_LOW;
    else if (extCode == CODE_LOW) kindIn = KIND_LOW;
    else if (extCode == CODE_UU)  kindIn = KIND_UU;
    else if (extCode == CODE_SU)  kindIn = KIND_SU;
    else                          kindIn = KIND_SS;
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = (state == ST_IDLE) && start;
    ctl.step    = (state == ST_RUN);
    ctl.fixA    = (state == ST_FIXA);
    ctl.fixB    = (state == ST_FIXB);
    ctl.publish = (state == ST_PUB);
    ctl.pickLow = (kind == KIND_LOW);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = ST_RUN;
      ST_RUN:  if (stepsLeft == CW'(1))
                 stateNext = (kind == KIND_LOW || kind == KIND_UU) ? ST_PUB : ST_FIXA;
      ST_FIXA: stateNext = (kind == KIND_SU) ? ST_PUB : ST_FIXB;
      ST_FIXB: stateNext = ST_PUB;
      ST_PUB:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= KIND_LOW;
      stepsLeft <= '0;
      done      <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= ctl.publish;
      if (ctl.load) begin
        kind      <= kindIn;
        stepsLeft <= CW'(W);
      end else if (ctl.step) begin
        stepsLeft <= stepsLeft - CW'(1);
      end
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/mulDatapath.sv
module mulDatapath #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  mulPkg::mulCtl_t ctl,
  input  logic            immMode,
  input  logic [W-1:0]    opA,
  input  logic [W-1:0]    opB,
  input  logic [IW-1:0]   imm16,
  output logic [W-1:0]    result
);
  logic [W-1:0] mcand, mplOrig, mplLeft, mplRight, loAcc, hiAcc;
  logic [W-1:0] bSel, loAdd;
  logic [W:0]   hiSum;

  assign bSel  = immMode ? {{(W-IW){imm16[IW-1]}}, imm16} : opB;
  assign loAdd = mplLeft[W-1] ? mcand : '0;
  assign hiSum = {1'b0, hiAcc} + (mplRight[0] ? {1'b0, mcand} : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand    <= '0;
      mplOrig  <= '0;
      mplLeft  <= '0;
      mplRight <= '0;
      loAcc    <= '0;
      hiAcc    <= '0;
      result   <= '0;
    end else begin
      if (ctl.load) begin
        mcand    <= opA;
        mplOrig  <= bSel;
        mplLeft  <= bSel;
        mplRight <= bSel;
        loAcc    <= '0;
        hiAcc    <= '0;
      end
      if (ctl.step) begin
        loAcc    <= (loAcc << 1) + loAdd;
        mplLeft  <= mplLeft << 1;
        hiAcc    <= hiSum[W:1];
        mplRight <= mplRight >> 1;
      end
      if (ctl.fixA && mcand[W-1])   hiAcc <= hiAcc - mplOrig;
      if (ctl.fixB && mplOrig[W-1]) hiAcc <= hiAcc - mcand;
      if (ctl.publish) result <= ctl.pickLow ? loAcc : hiAcc;
    end
  end
endmodule

// File: rtl/iterMul.sv
module iterMul #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          immMode,
  input  logic [5:0]    extCode,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic [IW-1:0] imm16,
  output logic [W-1:0]  result,
  output logic          done,
  output logic          busy
);
  mulPkg::mulCtl_t ctl;

  mulCtrl #(.W(W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .immMode(immMode),
    .extCode(extCode), .ctl(ctl), .busy(busy), .done(done)
  );

  mulDatapath #(.W(W), .IW(IW)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .immMode(immMode),
    .opA(opA), .opB(opB), .imm16(imm16), .result(result)
  );
endmodule

// File: rtl/iterMulChk.sv
module iterMulChk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result
);
  logic [15:0] busyCycles;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                busyCycles <= '0;
    else if (start && !busy)  busyCycles <= '0;
    else if (busy)            busyCycles <= busyCycles + 16'd1;
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done);

  assert_latency_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCycles >= 16'(W + 1) && busyCycles <= 16'(W + 3)));
endmodule

bind iterMul iterMulChk #(.W(W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .result(result)
);

// File: tb/sim_iterMul.sv
module sim_iterMul;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        immMode = 1'b0;
  logic [5:0]  extCode = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [15:0] imm16 = '0;
  logic [31:0] result;
  logic        done, busy;

  iterMul u0 (
    .clk(clk), .rstN(rstN), .start(start), .immMode(immMode), .extCode(extCode),
    .opA(opA), .opB(opB), .imm16(imm16), .result(result), .done(done), .busy(busy)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [31:0] res;
    int          lat;
    int          stamp;
    string       tag;
  } item_t;

  item_t q[$];
  int nChecks = 0, nFails = 0, cycCnt = 0;
  bit finished = 0;

  always @(posedge clk) cycCnt <= cycCnt + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refWord(input bit imm, input logic [5:0] code,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [15:0] i);
    logic [63:0] p;
    logic [63:0] ax, bx;
    if (imm) begin
      bx = {{48{i[15]}}, i};
      p = {32'b0, a} * bx;
      return p[31:0];
    end
    if (code == 6'h27) begin p = {32'b0, a} * {32'b0, b}; return p[31:0]; end
    if (code == 6'h07) begin p = {32'b0, a} * {32'b0, b}; return p[63:32]; end
    ax = {{32{a[31]}}, a};
    bx = (code == 6'h17) ? {32'b0, b} : {{32{b[31]}}, b};
    p = ax * bx;
    return p[63:32];
  endfunction

  function automatic string tagOf(input bit imm, input logic [5:0] code);
    if (imm) return "R5";
    if (code == 6'h27) return "R1";
    if (code == 6'h07) return "R2";
    if (code == 6'h17) return "R3";
    return "R4";
  endfunction

  function automatic int latOf(input bit imm, input logic [5:0] code);
    if (imm || code == 6'h27 || code == 6'h07) return 34;
    if (code == 6'h17) return 35;
    return 36;
  endfunction

  // Driver: pushes the expectation, optionally fires an ignored start mid-run (R8).
  task automatic issue(input bit imm, input logic [5:0] code, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] i, input bit poke);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    immMode = imm; extCode = code; opA = a; opB = b; imm16 = i;
    start = 1'b1;
    it.res = refWord(imm, code, a, b, i);
    it.lat = latOf(imm, code);
    it.stamp = cycCnt;
    it.tag = tagOf(imm, code);
    q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      immMode = ~imm; extCode = 6'h1f; opA = ~a; opB = ~b; imm16 = ~i;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  // Monitor: compares each completed result and its delay.
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        if (q.size() == 0) begin
          check(1'b0, "R8 unexpected done", result, 32'h0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(result === it.res, it.tag, result, it.res);
          check((cycCnt - it.stamp) == it.lat, "R6 latency",
                32'(cycCnt - it.stamp), 32'(it.lat));
        end
      end
    end
  end

  task automatic finish;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog R6 actual=%08h expected=%08h", 32'(cycCnt), 32'h0);
    finish();
  end

  logic [31:0] corners [5] = '{32'h0, 32'h1, 32'hffffffff, 32'h80000000, 32'h7fffffff};
  logic [5:0]  codes [6]   = '{6'h27, 6'h07, 6'h17, 6'h1f, 6'h00, 6'h3a};

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(result == 32'h0, "R9 result", result, 32'h0);
    check(done == 1'b0, "R9 done", {31'b0, done}, 32'h0);
    check(busy == 1'b0, "R9 busy", {31'b0, busy}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(result == 32'h0 && !busy && !done, "R9 after release", result, 32'h0);

    // R1..R4 on corner operands, every code
    foreach (codes[c])
      foreach (corners[x])
        foreach (corners[y])
          issue(1'b0, codes[c], corners[x], corners[y], 16'h0, 1'b0);

    // R5: immediate corners, extCode and opB set to distracting values
    foreach (corners[x]) begin
      issue(1'b1, 6'h07, corners[x], 32'hdeadbeef, 16'hffff, 1'b0);
      issue(1'b1, 6'h1f, corners[x], 32'h12345678, 16'h8000, 1'b0);
      issue(1'b1, 6'h17, corners[x], 32'h0, 16'h7fff, 1'b0);
      issue(1'b1, 6'h27, corners[x], 32'hffffffff, 16'h0001, 1'b0);
    end

    // Random operands across modes, with ignored starts mid-run (R8)
    for (int n = 0; n < 60; n++) begin
      logic [31:0] a, b;
      logic [15:0] i;
      a = $urandom(); b = $urandom(); i = 16'($urandom());
      issue(1'b0, codes[n % 6], a, b, i, n[0]);
      if (n % 4 == 0) issue(1'b1, codes[n % 6], a, b, i, 1'b1);
    end

    // R8: no stray done after the last ignored start
    repeat (50) @(negedge clk);
    check(q.size() == 0, "R8 queue drained", 32'(q.size()), 32'h0);
    finish();
  end
endmodule